// File: doc/BRIEF.md
# Scaled Saturating Pixel Pack Unit

This block turns wide signed fixed-point lanes into narrow saturated pixel values in one registered step. A scale factor taken from a status word shifts every lane left. A fixed post-shift then drops the fraction bits, and a clamp bounds the result to the width of the output lane. A mode select picks one of three conversions. The first packs four signed 16-bit lanes into unsigned bytes. The second packs two signed 32-bit words into unsigned bytes and merges them into a copy of a second operand shifted left by one byte. The third packs two signed 32-bit words into signed 16-bit halves.

A caller presents the status word, both sources and the mode together with `in_valid`. The packed result appears on `result` with `out_valid` one clock later. The result register holds its value on cycles without `in_valid`. All scaling is done at 64-bit width, so even the largest scale cannot wrap a value before it is clamped.

Top module: `pixel_pack_unit`

## Requirements
- R1: Mode encoding on `mode_sel`: 0 packs 16-bit lanes to unsigned bytes, 1 packs 32-bit words to unsigned bytes with merge, 2 packs 32-bit words to signed 16-bit, and 3 is reserved. Mode 0 takes its 4-bit scale from `status_in[6:3]` and ignores `status_in[7]`. Modes 1 and 2 take a 5-bit scale from `status_in[7:3]`.
- R2: In mode 0, lane k is `src_b[16k+15:16k]`, read as signed. It is shifted left by the scale, then shifted right arithmetically by 7, and the result goes to `result[8k+7:8k]`. `result[63:32]` is zero.
- R3: In mode 0, a lane whose shifted value is negative gives 0, and a lane whose shifted value is above 255 gives 255.
- R4: In mode 1, the result starts as `src_a` shifted left by 8, with bits 7:0 and 39:32 cleared.
- R5: In mode 1, signed word k of `src_b` is scaled, shifted right arithmetically by 23 and clamped to 0..255. It is placed in `result[32k+7:32k]`.
- R6: In mode 2, signed word k of `src_b` is scaled, shifted right arithmetically by 16 and clamped to -32768..32767. It is placed in `result[16k+15:16k]` as two's complement, and `result[63:32]` is zero.
- R7: Scaling is done at 64-bit width. With scale 31, a 32-bit word of 1 saturates to the upper bound rather than wrapping negative.
- R8: `result` and `out_valid` update one clock after a cycle with `in_valid` high. After a cycle with `in_valid` low, `out_valid` is low and `result` is unchanged.
- R9: A synchronous reset clears `out_valid` and `result` to zero.
- R10: Mode 3 gives an all-zero result with `out_valid` still set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid this cycle |
| mode_sel | input | 2 | Conversion mode (R1 encoding) |
| status_in | input | 64 | Status word carrying the scale field |
| src_a | input | 64 | Operand shifted into the merge result |
| src_b | input | 64 | Fixed-point lanes to pack |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Packed result |

## Verification
The hardest case to reach from the ports is a value that would wrap in 32-bit arithmetic but must saturate here. It only appears with a near-maximum scale and lanes close to the sign boundary. The stimulus sweeps every scale value in every mode against lane patterns holding the extreme positive and negative values and small magnitudes, plus pseudo-random words. Random bits are placed in the unused status bits so that a scale field decoded from the wrong bits shows up. Directed vectors also pin scale 31 against words of 1 and -1, and set status bit 7 while in the 16-bit mode.

// File: rtl/pk_pkg.sv
package pk_pkg;
    localparam int PK_DATA_W   = 64;
    localparam int PK_EXT_W    = 64;
    localparam int PK_SC_LSB   = 3;
    localparam int PK_SC_NAR_W = 4;
    localparam int PK_SC_WID_W = 5;
    localparam int PK_SH_B16   = 7;
    localparam int PK_SH_B32   = 23;
    localparam int PK_SH_FIX   = 16;
    localparam int PK_HALF_W   = PK_DATA_W / 2;
    localparam logic [PK_DATA_W-1:0] PK_MERGE_CLR = 64'h0000_00FF_0000_00FF;

    typedef enum logic [1:0] {
        PK_U8_FROM16  = 2'd0,
        PK_U8_MERGE32 = 2'd1,
        PK_S16_FROM32 = 2'd2,
        PK_RSVD       = 2'd3
    } pk_mode_e;

    typedef struct packed {
        logic                 valid;
        pk_mode_e             mode;
        logic [PK_DATA_W-1:0] data;
    } pk_out_s;

    function automatic logic [PK_SC_WID_W-1:0] pk_scale(input logic [PK_DATA_W-1:0] st,
                                                        input pk_mode_e m);
        logic [PK_SC_WID_W-1:0] s;
        s = st[PK_SC_LSB +: PK_SC_WID_W];
        if (m == PK_U8_FROM16) s[PK_SC_WID_W-1] = 1'b0;
        return s;
    endfunction
endpackage

// File: rtl/pk_sat_lane.sv
module pk_sat_lane #(
    parameter int IN_W       = 16,
    parameter int SCALE_W    = 4,
    parameter int POST_SH    = 7,
    parameter int OUT_W      = 8,
    parameter bit SIGNED_OUT = 1'b0
) (
    input  logic [IN_W-1:0]    din,
    input  logic [SCALE_W-1:0] scale,
    output logic [OUT_W-1:0]   dout
);
    localparam int EXT_W = pk_pkg::PK_EXT_W;
    localparam logic signed [EXT_W-1:0] HI_LIM = SIGNED_OUT ?
        (64'sd1 <<< (OUT_W - 1)) - 64'sd1 : (64'sd1 <<< OUT_W) - 64'sd1;
    localparam logic signed [EXT_W-1:0] LO_LIM = SIGNED_OUT ?
        -(64'sd1 <<< (OUT_W - 1)) : 64'sd0;

    logic signed [EXT_W-1:0] wide;
    logic signed [EXT_W-1:0] scaled;
    logic signed [EXT_W-1:0] trimmed;

    always_comb begin
        wide    = {{(EXT_W-IN_W){din[IN_W-1]}}, din};
        scaled  = wide <<< scale;
        trimmed = scaled >>> POST_SH;
        if (trimmed > HI_LIM)      dout = HI_LIM[OUT_W-1:0];
        else if (trimmed < LO_LIM) dout = LO_LIM[OUT_W-1:0];
        else                       dout = trimmed[OUT_W-1:0];
    end

    generate
        if (SIGNED_OUT) begin : g_sgn_chk
            always_comb begin
                // R6: the sign of the input survives the clamp
                a_r6_sign_kept: assert (dout[OUT_W-1] == din[IN_W-1]);
            end
        end else begin : g_uns_chk
            always_comb begin
                if (din[IN_W-1]) begin
                    a_r3_neg_to_zero: assert (dout == '0);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/pk_lane_array.sv
module pk_lane_array #(
    parameter int N_LANES    = 4,
    parameter int IN_W       = 16,
    parameter int SCALE_W    = 4,
    parameter int POST_SH    = 7,
    parameter int OUT_W      = 8,
    parameter bit SIGNED_OUT = 1'b0
) (
    input  logic [N_LANES*IN_W-1:0]  din_vec,
    input  logic [SCALE_W-1:0]       scale,
    output logic [N_LANES*OUT_W-1:0] dout_vec
);
    genvar k;
    generate
        for (k = 0; k < N_LANES; k++) begin : g_lane
            pk_sat_lane #(
                .IN_W      (IN_W),
                .SCALE_W   (SCALE_W),
                .POST_SH   (POST_SH),
                .OUT_W     (OUT_W),
                .SIGNED_OUT(SIGNED_OUT)
            ) lane_i (
                .din  (din_vec[k*IN_W +: IN_W]),
                .scale(scale),
                .dout (dout_vec[k*OUT_W +: OUT_W])
            );
        end
    endgenerate
endmodule

// File: rtl/pixel_pack_unit.sv
module pixel_pack_unit
    import pk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [1:0]           mode_sel,
    input  logic [PK_DATA_W-1:0] status_in,
    input  logic [PK_DATA_W-1:0] src_a,
    input  logic [PK_DATA_W-1:0] src_b,
    output logic                 out_valid,
    output logic [PK_DATA_W-1:0] result
);
    localparam int N16 = PK_DATA_W / 16;
    localparam int N32 = PK_DATA_W / 32;

    pk_mode_e               mode_in;
    logic [PK_SC_WID_W-1:0] scale_sel;
    logic [N16*8-1:0]       bytes16;
    logic [N32*8-1:0]       bytes32;
    logic [N32*16-1:0]      halves32;
    logic [PK_DATA_W-1:0]   merge_word;
    logic [PK_DATA_W-1:0]   pack_next;
    pk_out_s                out_q;

    assign mode_in   = pk_mode_e'(mode_sel);
    assign scale_sel = pk_scale(status_in, mode_in);

    pk_lane_array #(
        .N_LANES(N16), .IN_W(16), .SCALE_W(PK_SC_NAR_W),
        .POST_SH(PK_SH_B16), .OUT_W(8), .SIGNED_OUT(1'b0)
    ) arr_b16_i (
        .din_vec (src_b),
        .scale   (scale_sel[PK_SC_NAR_W-1:0]),
        .dout_vec(bytes16)
    );

    pk_lane_array #(
        .N_LANES(N32), .IN_W(32), .SCALE_W(PK_SC_WID_W),
        .POST_SH(PK_SH_B32), .OUT_W(8), .SIGNED_OUT(1'b0)
    ) arr_b32_i (
        .din_vec (src_b),
        .scale   (scale_sel),
        .dout_vec(bytes32)
    );

    pk_lane_array #(
        .N_LANES(N32), .IN_W(32), .SCALE_W(PK_SC_WID_W),
        .POST_SH(PK_SH_FIX), .OUT_W(16), .SIGNED_OUT(1'b1)
    ) arr_fix_i (
        .din_vec (src_b),
        .scale   (scale_sel),
        .dout_vec(halves32)
    );

    always_comb begin
        merge_word = (src_a << 8) & ~PK_MERGE_CLR;
        for (int k = 0; k < N32; k++) begin
            merge_word[k*32 +: 8] = bytes32[k*8 +: 8];
        end
    end

    always_comb begin
        pack_next = '0;
        case (mode_in)
            PK_U8_FROM16:  pack_next[PK_HALF_W-1:0] = bytes16;
            PK_U8_MERGE32: pack_next = merge_word;
            PK_S16_FROM32: pack_next[PK_HALF_W-1:0] = halves32;
            default:       pack_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '{valid: 1'b0, mode: PK_U8_FROM16, data: '0};
        end else begin
            out_q.valid <= in_valid;
            if (in_valid) begin
                out_q.mode <= mode_in;
                out_q.data <= pack_next;
            end
        end
    end

    assign out_valid = out_q.valid;
    assign result    = out_q.data;

    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r8_idle_low: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));
    a_r4_merge_base: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_q.mode == PK_U8_MERGE32) |->
        (result[31:8] == $past(src_a[23:0]) && result[63:40] == $past(src_a[55:32])));
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_q.mode != PK_U8_MERGE32) |-> result[63:32] == '0);
    a_r10_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_q.mode == PK_RSVD) |-> result == '0);
endmodule

// File: tb/pixel_pack_unit_tb.sv
module pixel_pack_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  mode_sel;
    logic [63:0] status_in, src_a, src_b;
    logic        out_valid;
    logic [63:0] result;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    always #(CLK_PERIOD/2) clk = ~clk;

    pixel_pack_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode_sel(mode_sel),
        .status_in(status_in), .src_a(src_a), .src_b(src_b),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] next_rnd(input logic [63:0] x);
        logic [63:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 7);
        y = y ^ (y << 17);
        return y;
    endfunction

    function automatic longint clampv(input longint v, input longint lo, input longint hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic logic [63:0] model(input logic [1:0] m, input logic [63:0] st,
                                          input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r;
        longint v, f;
        int sc;
        r = '0;
        case (m)
            2'd0: begin
                sc = int'(st[6:3]);
                for (int k = 0; k < 4; k++) begin
                    v = longint'($signed(b[16*k +: 16]));
                    f = clampv((v <<< sc) >>> 7, 0, 255);
                    r[8*k +: 8] = f[7:0];
                end
            end
            2'd1: begin
                sc = int'(st[7:3]);
                r = (a << 8) & ~64'h0000_00FF_0000_00FF;
                for (int k = 0; k < 2; k++) begin
                    v = longint'($signed(b[32*k +: 32]));
                    f = clampv((v <<< sc) >>> 23, 0, 255);
                    r[32*k +: 8] = f[7:0];
                end
            end
            2'd2: begin
                sc = int'(st[7:3]);
                for (int k = 0; k < 2; k++) begin
                    v = longint'($signed(b[32*k +: 32]));
                    f = clampv((v <<< sc) >>> 16, -32768, 32767);
                    r[16*k +: 16] = f[15:0];
                end
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after capture.
    task automatic txn(input logic [1:0] m, input logic [63:0] st, input logic [63:0] a,
                       input logic [63:0] b, input string req);
        logic [63:0] exp;
        exp = model(m, st, a, b);
        mode_sel = m; status_in = st; src_a = a; src_b = b; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check({req, " R8 valid"}, {63'd0, out_valid}, 64'd1);
        check(req, result, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        logic [63:0] pat;
        logic [63:0] st;
        rst = 1'b1; in_valid = 1'b1; mode_sel = 2'd1;
        status_in = '1; src_a = '1; src_b = 64'h7FFF_7FFF_7FFF_7FFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 out_valid", {63'd0, out_valid}, 64'd0);
        check("R9 result", result, 64'd0);
        rst = 1'b0; in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);

        // Directed boundaries
        txn(2'd0, 64'h0, 64'h0, 64'h8000_0080_7FFF_0100, "R2 R3 scale0");
        txn(2'd0, 64'h0000_0000_0000_0080, 64'h0, 64'h0000_0000_0000_0080, "R1 bit7 ignored");
        txn(2'd0, 64'h78, 64'h0, 64'hFFFF_0001_8000_4000, "R3 max scale");
        txn(2'd1, 64'h0, 64'h1122_3344_5566_7788, 64'h7FFF_FFFF_0080_0000, "R4 R5 scale0");
        txn(2'd1, 64'hF8, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, "R5 max scale");
        txn(2'd2, 64'hF8, 64'h0, 64'hFFFF_FFFF_0000_0001, "R7 wide scale");
        txn(2'd2, 64'h0, 64'h0, 64'h8000_0000_7FFF_FFFF, "R6 scale0");
        txn(2'd3, 64'hFF, 64'hDEAD_BEEF_0123_4567, 64'h1234_5678_9ABC_DEF0, "R10 reserved");

        // R8: idle cycle keeps result and drops out_valid
        held = result;
        in_valid = 1'b0; mode_sel = 2'd1; src_a = '1; src_b = '1; status_in = '1;
        @(posedge clk);
        @(negedge clk);
        check("R8 idle valid", {63'd0, out_valid}, 64'd0);
        check("R8 idle hold", result, held);

        // Sweep every mode and scale value
        for (int m = 0; m < 4; m++) begin
            for (int sc = 0; sc < 32; sc++) begin
                for (int p = 0; p < 6; p++) begin
                    rng = next_rnd(rng);
                    case (p)
                        0: pat = 64'h8000_7FFF_0001_FFFF;
                        1: pat = 64'h7FFF_FFFF_8000_0000;
                        2: pat = 64'h0000_0080_0080_0100;
                        default: pat = rng;
                    endcase
                    st = next_rnd(rng ^ 64'h55);
                    st[7:3] = sc[4:0];
                    txn(m[1:0], st, next_rnd(pat ^ rng), pat,
                        m == 0 ? "R1 R2 R3 sweep" : m == 1 ? "R4 R5 sweep" :
                        m == 2 ? "R6 R7 sweep" : "R10 sweep");
                end
            end
        end

        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R8 final idle", {63'd0, out_valid}, 64'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule